// File: doc/BRIEF.md
# Serial Program Loader for Instruction Memory

This block fills an instruction memory from a serial link. It watches an asynchronous receive line that carries 8N1 frames. The line idles high. Each frame has one low start bit, eight data bits sent least-significant bit first, and one high stop bit. Each group of four good bytes becomes one 32-bit instruction word. The first byte received fills the lowest byte of the word. The finished word goes out on a memory write port as a single-cycle write.

Word addresses begin at zero and step by one after every write. A host therefore streams the program in order, one instruction after another, and the memory holds the image from address 0 upward. A running count of written words shows how far the load has gone. A one-cycle pulse reports any frame whose stop bit was sampled low. Such a byte is dropped and does not move the assembly position within the current word.

Top module: `uart_word_loader`

## Requirements
- R1: After reset, mem_we and frame_err are low, and mem_addr and words_loaded are both zero.
- R2: A frame is a low start bit, eight data bits least-significant bit first, and a high stop bit, each lasting CLKS_PER_BIT clocks. Every data bit and the stop bit are sampled at the middle of their bit period.
- R3: Four accepted bytes form one word with the first byte in bits 7:0, the second in 15:8, the third in 23:16 and the fourth in 31:24. For example, bytes 0x93 0x02 0x10 0x04 give 0x04100293.
- R4: The first word is written to address 0, and each later word is written to the address one above the previous write.
- R5: mem_we is high for exactly one clock per completed word, and mem_addr and mem_wdata are valid in that clock.
- R6: words_loaded rises by one in the clock after each write, so it always equals the number of words written since reset.
- R7: A frame whose stop bit is sampled low produces no byte and a frame_err pulse of exactly one clock. The byte position inside the word being assembled is left unchanged.
- R8: A low excursion on rx that has ended by half a bit period after its falling edge is not taken as a start bit and produces no byte and no frame_err.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx | input | 1 | Asynchronous serial receive line, idles high |
| mem_we | output | 1 | Instruction memory write strobe, one clock per word |
| mem_addr | output | ADDR_W | Word address for the current write |
| mem_wdata | output | 32 | Assembled instruction word |
| words_loaded | output | ADDR_W+1 | Number of words written since reset |
| frame_err | output | 1 | One-clock pulse when a stop bit is sampled low |

## Verification
The assertions assume that frames are spaced by at least one stop-bit period. Under that assumption a write strobe can never fall in two adjacent clocks, and a frame error can never coincide with an accepted byte. The assertions also assume that fewer than 2^ADDR_W words are loaded, so the address never wraps. The bench respects all of this. It drives rx only on falling clock edges, holds each bit for exactly CLKS_PER_BIT clocks, and leaves idle time between frames. It sends a small program, so the address range is never exhausted. Its glitches last well under half a bit period.

// File: rtl/uart_boot_pkg.sv
package uart_boot_pkg;
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/boot_rx_sync.sv
module boot_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_async,
    output logic rx_sync
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], rx_async};
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= chain_d;
    end

    assign rx_sync = chain_q[STAGES-1];
endmodule

// File: rtl/boot_rx_frame.sv
module boot_rx_frame
    import uart_boot_pkg::*;
#(
    parameter int CLKS_PER_BIT = 868
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_s,
    output logic       byte_valid,
    output logic [7:0] byte_data,
    output logic       frame_bad
);
    localparam int CNT_W = $clog2(CLKS_PER_BIT);
    localparam logic [CNT_W-1:0] FULL_RELOAD = CNT_W'(CLKS_PER_BIT - 1);
    localparam logic [CNT_W-1:0] HALF_RELOAD = CNT_W'(CLKS_PER_BIT / 2 - 1);

    typedef struct packed {
        rx_state_e        state;
        logic [CNT_W-1:0] cnt;
        logic [2:0]       bit_idx;
        logic [7:0]       shreg;
        logic             prev;
        logic             valid;
        logic             bad;
    } rx_regs_t;

    rx_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.bad   = 1'b0;
        r_d.prev  = rx_s;
        unique case (r_q.state)
            RX_IDLE: begin
                if (r_q.prev && !rx_s) begin
                    r_d.state = RX_START;
                    r_d.cnt   = HALF_RELOAD;
                end
            end
            RX_START: begin
                if (r_q.cnt == '0) begin
                    if (!rx_s) begin
                        r_d.state   = RX_DATA;
                        r_d.cnt     = FULL_RELOAD;
                        r_d.bit_idx = '0;
                    end else begin
                        r_d.state = RX_IDLE;
                    end
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            RX_DATA: begin
                if (r_q.cnt == '0) begin
                    r_d.shreg = {rx_s, r_q.shreg[7:1]};
                    r_d.cnt   = FULL_RELOAD;
                    if (r_q.bit_idx == 3'd7) r_d.state = RX_STOP;
                    else                     r_d.bit_idx = r_q.bit_idx + 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            RX_STOP: begin
                if (r_q.cnt == '0) begin
                    if (rx_s) r_d.valid = 1'b1;
                    else      r_d.bad   = 1'b1;
                    r_d.state = RX_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            default: r_d.state = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q       <= '0;
            r_q.state <= RX_IDLE;
            r_q.prev  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign byte_valid = r_q.valid;
    assign byte_data  = r_q.shreg;
    assign frame_bad  = r_q.bad;

    // R7: a bad frame never also yields a byte, and its pulse lasts one clock
    p_bad_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(byte_valid && frame_bad));
    p_bad_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        frame_bad |=> !frame_bad);
    // R2: frame completion always leaves the receiver waiting for a new start
    p_back_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (byte_valid || frame_bad) |-> r_q.state == RX_IDLE);
endmodule

// File: rtl/boot_word_pack.sv
module boot_word_pack #(
    parameter int ADDR_W = 10,
    parameter int BYTES  = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                byte_valid,
    input  logic [7:0]          byte_data,
    input  logic                frame_bad,
    output logic                we,
    output logic [ADDR_W-1:0]   addr,
    output logic [8*BYTES-1:0]  wdata,
    output logic [ADDR_W:0]     count
);
    localparam int DATA_W = 8 * BYTES;
    localparam int POS_W  = $clog2(BYTES);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(BYTES - 1);

    typedef struct packed {
        logic [POS_W-1:0]  pos;
        logic [DATA_W-1:0] asm_word;
        logic              we;
        logic [DATA_W-1:0] wdata;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W:0]   count;
    } pack_regs_t;

    pack_regs_t p_d, p_q;
    logic [DATA_W-1:0] merged;

    always_comb begin
        merged = p_q.asm_word;
        merged[8*p_q.pos +: 8] = byte_data;

        p_d    = p_q;
        p_d.we = 1'b0;
        if (p_q.we) begin
            p_d.addr  = p_q.addr + 1'b1;
            p_d.count = p_q.count + 1'b1;
        end
        if (byte_valid) begin
            p_d.asm_word = merged;
            if (p_q.pos == LAST_POS) begin
                p_d.we    = 1'b1;
                p_d.wdata = merged;
                p_d.pos   = '0;
            end else begin
                p_d.pos = p_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) p_q <= '0;
        else     p_q <= p_d;
    end

    assign we    = p_q.we;
    assign addr  = p_q.addr;
    assign wdata = p_q.wdata;
    assign count = p_q.count;

    p_we_single_r5: assert property (@(posedge clk) disable iff (rst)
        we |=> !we);
    p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
        we |=> addr == $past(addr) + 1'b1);
    p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
        we |=> count == $past(count) + 1'b1);
    p_pos_hold_r7: assert property (@(posedge clk) disable iff (rst)
        frame_bad |=> p_q.pos == $past(p_q.pos));
endmodule

// File: rtl/uart_word_loader.sv
module uart_word_loader #(
    parameter int CLKS_PER_BIT = 868,
    parameter int ADDR_W       = 10,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [ADDR_W:0]   words_loaded,
    output logic              frame_err
);
    logic       rx_s;
    logic       byte_valid;
    logic [7:0] byte_data;
    logic       frame_bad;

    boot_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .rx_async(rx), .rx_sync(rx_s)
    );

    boot_rx_frame #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_frame (
        .clk(clk), .rst(rst), .rx_s(rx_s),
        .byte_valid(byte_valid), .byte_data(byte_data), .frame_bad(frame_bad)
    );

    boot_word_pack #(.ADDR_W(ADDR_W), .BYTES(4)) u_pack (
        .clk(clk), .rst(rst),
        .byte_valid(byte_valid), .byte_data(byte_data), .frame_bad(frame_bad),
        .we(mem_we), .addr(mem_addr), .wdata(mem_wdata), .count(words_loaded)
    );

    assign frame_err = frame_bad;

    // R1: outputs quiet in the clock after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!mem_we && !frame_err && words_loaded == '0));
endmodule

// File: tb/sim_uart_word_loader.sv
`timescale 1ns / 1ps
module sim_uart_word_loader;
    localparam int CPB    = 16;
    localparam int ADDR_W = 6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rx  = 1'b1;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0]       mem_wdata;
    logic [ADDR_W:0]   words_loaded;
    logic              frame_err;

    int checks = 0;
    int errors = 0;
    int sent_words = 0;
    int ferr_total = 0;
    int exp_words = 0;
    logic [31:0] exp_data[$];
    logic [ADDR_W-1:0] exp_addr[$];

    always #2 clk = ~clk;

    uart_word_loader #(.CLKS_PER_BIT(CPB), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst(rst), .rx(rx),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .words_loaded(words_loaded), .frame_err(frame_err)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold_bits(input int n);
        repeat (n * CPB) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit good_stop);
        @(negedge clk) rx = 1'b0;
        hold_bits(1);
        for (int i = 0; i < 8; i++) begin
            rx = b[i];
            hold_bits(1);
        end
        rx = good_stop;
        hold_bits(1);
        rx = 1'b1;
        hold_bits(2);
    endtask

    task automatic send_word(input logic [31:0] w);
        exp_data.push_back(w);
        exp_addr.push_back(ADDR_W'(sent_words));
        sent_words++;
        for (int k = 0; k < 4; k++) send_byte(w[8*k +: 8], 1'b1);
    endtask

    // monitor / scoreboard
    bit prev_we = 0;
    bit prev_fe = 0;
    bit cnt_pending = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (cnt_pending) begin
                check(words_loaded == (ADDR_W+1)'(exp_words), "R6 count", words_loaded, exp_words);
                cnt_pending = 0;
            end
            if (mem_we) begin
                check(!prev_we, "R5 single-cycle strobe", 1, 0);
                if (exp_data.size() == 0) begin
                    check(0, "R4 unexpected write", mem_wdata, 0);
                end else begin
                    logic [31:0] ed;
                    logic [ADDR_W-1:0] ea;
                    ed = exp_data.pop_front();
                    ea = exp_addr.pop_front();
                    check(mem_wdata == ed, "R2 R3 word data", mem_wdata, ed);
                    check(mem_addr == ea, "R4 word address", mem_addr, ea);
                end
                exp_words++;
                cnt_pending = 1;
            end
            if (frame_err) begin
                check(!prev_fe, "R7 pulse width", 1, 0);
                ferr_total++;
            end
            prev_we = mem_we;
            prev_fe = frame_err;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(mem_we == 0, "R1 we", mem_we, 0);
        check(mem_addr == 0, "R1 addr", mem_addr, 0);
        check(words_loaded == 0, "R1 count", words_loaded, 0);
        check(frame_err == 0, "R1 frame_err", frame_err, 0);
        hold_bits(2);

        // R2 R3 R4: small program, mixed bit patterns
        send_word(32'h04100293);
        send_word(32'hffc00313);
        send_word(32'h00532023);
        send_word(32'h0000006f);
        send_word(32'hA5FF0180);

        // R7: bad stop after two bytes, then the rest of the word
        exp_data.push_back(32'h11223344);
        exp_addr.push_back(ADDR_W'(sent_words));
        sent_words++;
        send_byte(8'h44, 1'b1);
        send_byte(8'h33, 1'b1);
        send_byte(8'hEE, 1'b0);
        check(ferr_total == 1, "R7 frame_err seen", ferr_total, 1);
        check(words_loaded == (ADDR_W+1)'(5), "R7 no write on bad byte", words_loaded, 5);
        send_byte(8'h22, 1'b1);
        send_byte(8'h11, 1'b1);

        // R8: short glitches must not start a frame
        for (int g = 0; g < 3; g++) begin
            @(negedge clk) rx = 1'b0;
            repeat (CPB / 4) @(negedge clk);
            rx = 1'b1;
            hold_bits(3);
        end
        check(ferr_total == 1, "R8 no frame_err from glitch", ferr_total, 1);
        check(words_loaded == (ADDR_W+1)'(6), "R8 no write from glitch", words_loaded, 6);
        send_word(32'hDEADBEEF);

        hold_bits(2);
        check(exp_data.size() == 0, "R4 all words written", exp_data.size(), 0);
        check(words_loaded == (ADDR_W+1)'(sent_words), "R6 final count", words_loaded, sent_words);
        check(mem_addr == ADDR_W'(sent_words), "R4 next address", mem_addr, sent_words);
        check(ferr_total == 1, "R7 total frame errors", ferr_total, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule